// File: doc/BRIEF.md
# Hybrid Tagged/Untagged Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two tables of saturating counters. The first is small and tagged: each entry stores the upper PC bits of the branch that owns it, so it only answers for that branch. The second is larger and untagged: it is indexed by low PC bits alone, and it covers every branch that the tagged table does not recognise.

A fetch stage presents a PC on the lookup port and gets a prediction back in the same cycle. It also gets a flag that says which table produced the prediction. When the branch resolves, the outcome is presented on the update port. A tag hit trains only the tagged counter. A tag miss trains the untagged counter. On a miss, the tagged slot for that branch is also given to it, with a counter set to the weak state in the direction of the outcome.

Top module: `hyb_pred`

## Requirements
- R1: The low `TAG_IDX_W` bits of the PC select the tagged entry. The remaining `PC_W-TAG_IDX_W` upper bits are compared with the stored tag. A PC that shares the index but differs in any upper bit misses.
- R2: When the lookup PC hits a valid tagged entry, `lk_tagged` is 1 and the prediction comes from that entry's counter.
- R3: When the lookup PC misses, `lk_tagged` is 0 and the prediction comes from the untagged counter selected by the low `BASE_IDX_W` PC bits. An update that misses steps that untagged counter.
- R4: Every counter is `CNT_W` bits wide. A taken outcome increments it and a not-taken outcome decrements it. It holds at all-ones and at zero rather than wrapping.
- R5: The prediction is the counter's most significant bit. For 2-bit counters, states 00 and 01 predict not-taken and states 10 and 11 predict taken.
- R6: An update that misses writes the tagged entry at its index. The entry becomes valid, its tag is set to the upper PC bits, and its counter becomes 10 (weakly taken) for a taken outcome or 01 (weakly not-taken) for a not-taken outcome.
- R7: An update that hits steps only the tagged counter and leaves every untagged counter unchanged.
- R8: Reset clears every tagged valid bit and sets every counter to 01. After reset, every lookup misses and predicts not-taken until an entry has been allocated.
- R9: Lookup is combinational. An update is written on the rising clock edge, so an update to the entry being looked up in the same cycle does not change that cycle's prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC being predicted |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_tagged | output | 1 | 1 when the tagged table supplied the prediction |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The hardest case to reach from the ports is showing that a hit leaves the untagged table alone. The untagged counters can only be seen when a lookup misses, so their state is normally hidden behind a valid tagged entry. The stimulus first allocates a branch and trains it through several hits. It then looks up a second PC with the same low bits but a different tag. That lookup misses the tagged entry and exposes the untagged counter, which must still hold its old value. A randomized phase keeps the tags to a few values so that allocation, aliasing and eviction recur often, and compares every cycle against a behavioural model.

// File: rtl/hyb_pred_pkg.sv
package hyb_pred_pkg;

    typedef enum logic {
        SRC_UNTAGGED = 1'b0,
        SRC_TAGGED   = 1'b1
    } pred_src_e;

    // Saturating step for a counter of width w (w <= 8).
    function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                            input logic       up,
                                            input int unsigned w);
        logic [7:0] top;
        top = 8'((9'd1 << w) - 9'd1);
        if (up)
            return (cur == top) ? cur : cur + 8'd1;
        else
            return (cur == 8'd0) ? cur : cur - 8'd1;
    endfunction

endpackage

// File: rtl/hyb_tag_tbl.sv
module hyb_tag_tbl
    import hyb_pred_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  rd_pc,
    output logic             rd_hit,
    output logic [CNT_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic             wr_taken,
    output logic             wr_hit
);
    localparam int TAG_W   = PC_W - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] WEAK_T = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] WEAK_N = WEAK_T - CNT_W'(1);
    localparam logic [CNT_W-1:0] C_MAX  = '1;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] ctr;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;

    assign rd_idx = rd_pc[IDX_W-1:0];
    assign rd_tag = rd_pc[PC_W-1:IDX_W];
    assign wr_idx = wr_pc[IDX_W-1:0];
    assign wr_tag = wr_pc[PC_W-1:IDX_W];

    assign rd_hit = st_q.ent[rd_idx].vld && (st_q.ent[rd_idx].tag == rd_tag);
    assign rd_ctr = st_q.ent[rd_idx].ctr;
    assign wr_hit = st_q.ent[wr_idx].vld && (st_q.ent[wr_idx].tag == wr_tag);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_hit) begin
                st_d.ent[wr_idx].ctr =
                    CNT_W'(sat_step(8'(st_q.ent[wr_idx].ctr), wr_taken, CNT_W));
            end else begin
                st_d.ent[wr_idx].vld = 1'b1;
                st_d.ent[wr_idx].tag = wr_tag;
                st_d.ent[wr_idx].ctr = wr_taken ? WEAK_T : WEAK_N;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.ent[i].vld <= 1'b0;
                st_q.ent[i].tag <= '0;
                st_q.ent[i].ctr <= WEAK_N;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // A missing update must leave a valid entry owned by the new tag.
    assert_alloc_owns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> (st_q.ent[$past(wr_idx)].vld &&
                                st_q.ent[$past(wr_idx)].tag == $past(wr_tag)));

    // A saturated counter that is trained taken on a hit stays at the top.
    assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && wr_taken && st_q.ent[wr_idx].ctr == C_MAX)
        |=> (st_q.ent[$past(wr_idx)].ctr == C_MAX));

    // The first cycle after reset cannot hit.
    assert_cold_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !rd_hit);

endmodule

// File: rtl/hyb_base_tbl.sv
module hyb_base_tbl
    import hyb_pred_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] WEAK_N = (CNT_W'(1) << (CNT_W - 1)) - CNT_W'(1);

    typedef struct packed {
        logic [ENTRIES-1:0][CNT_W-1:0] ctr;
    } st_t;

    st_t st_d, st_q;

    assign rd_ctr = st_q.ctr[rd_idx];

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.ctr[wr_idx] = CNT_W'(sat_step(8'(st_q.ctr[wr_idx]), wr_taken, CNT_W));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                st_q.ctr[i] <= WEAK_N;
        end else begin
            st_q <= st_d;
        end
    end

    // Without a write strobe, the counter read last cycle is unchanged.
    assert_base_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (st_q.ctr[$past(rd_idx)] == $past(rd_ctr)));

endmodule

// File: rtl/hyb_pred.sv
module hyb_pred
    import hyb_pred_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int TAG_IDX_W  = 4,
    parameter int BASE_IDX_W = 6,
    parameter int CNT_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_tagged,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    logic             t_rd_hit, t_wr_hit;
    logic [CNT_W-1:0] t_rd_ctr, b_rd_ctr, sel_ctr;
    pred_src_e        src;

    hyb_tag_tbl #(.PC_W(PC_W), .IDX_W(TAG_IDX_W), .CNT_W(CNT_W)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (lk_pc),
        .rd_hit   (t_rd_hit),
        .rd_ctr   (t_rd_ctr),
        .wr_en    (up_valid),
        .wr_pc    (up_pc),
        .wr_taken (up_taken),
        .wr_hit   (t_wr_hit)
    );

    hyb_base_tbl #(.IDX_W(BASE_IDX_W), .CNT_W(CNT_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_pc[BASE_IDX_W-1:0]),
        .rd_ctr   (b_rd_ctr),
        .wr_en    (up_valid && !t_wr_hit),
        .wr_idx   (up_pc[BASE_IDX_W-1:0]),
        .wr_taken (up_taken)
    );

    always_comb begin
        src     = t_rd_hit ? SRC_TAGGED : SRC_UNTAGGED;
        sel_ctr = (src == SRC_TAGGED) ? t_rd_ctr : b_rd_ctr;
    end

    assign lk_taken  = sel_ctr[CNT_W-1];
    assign lk_tagged = (src == SRC_TAGGED);

    // An allocating update makes the same, unchanged PC hit on the next cycle.
    assert_alloc_then_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_pc == lk_pc) |=> ($stable(lk_pc) -> lk_tagged));

endmodule

// File: tb/hyb_pred_bench.sv
`timescale 1ns/1ps
module hyb_pred_bench;
    localparam int PC_W = 16, TI = 4, BI = 6, CW = 2;
    localparam int TE = 1 << TI, BE = 1 << BI, CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
    logic up_valid = 1'b0, up_taken = 1'b0;
    logic lk_taken, lk_tagged;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    bit m_vld [TE];
    int m_tag [TE];
    int m_tc  [TE];
    int m_bc  [BE];

    always #2.5 clk = ~clk;

    hyb_pred #(.PC_W(PC_W), .TAG_IDX_W(TI), .BASE_IDX_W(BI), .CNT_W(CW)) u_hyb_pred (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_tagged(lk_tagged), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    function automatic int step(int c, bit up);
        if (up) return (c == CMAX) ? c : c + 1;
        return (c == 0) ? c : c - 1;
    endfunction

    function automatic bit m_hit(logic [PC_W-1:0] pc);
        int ti = int'(pc[TI-1:0]);
        return m_vld[ti] && (m_tag[ti] == int'(pc[PC_W-1:TI]));
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic apply(input logic [PC_W-1:0] lpc, input bit uv,
                         input logic [PC_W-1:0] upc, input bit ut, input string req);
        bit eh, et;
        int ec, ti;
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        eh = m_hit(lpc);
        ec = eh ? m_tc[int'(lpc[TI-1:0])] : m_bc[int'(lpc[BI-1:0])];
        et = (ec >= (1 << (CW - 1)));
        vectors++;
        if (lk_taken !== et || lk_tagged !== eh) begin
            miscompares++;
            $display("FAIL %s pc=%h taken got %b exp %b, tagged got %b exp %b",
                     req, lpc, lk_taken, et, lk_tagged, eh);
        end
        if (uv) begin
            ti = int'(upc[TI-1:0]);
            if (m_hit(upc)) begin
                m_tc[ti] = step(m_tc[ti], ut);
            end else begin
                m_bc[int'(upc[BI-1:0])] = step(m_bc[int'(upc[BI-1:0])], ut);
                m_vld[ti] = 1'b1;
                m_tag[ti] = int'(upc[PC_W-1:TI]);
                m_tc[ti]  = ut ? 2 : 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic look(input logic [PC_W-1:0] lpc, input string req);
        apply(lpc, 1'b0, '0, 1'b0, req);
    endtask

    task automatic train(input logic [PC_W-1:0] upc, input bit ut, input string req);
        apply(16'hFFFF, 1'b1, upc, ut, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < TE; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tc[i] = 1; end
        for (int i = 0; i < BE; i++) m_bc[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: cold state misses and predicts not-taken
        look(16'h1234, "R8");
        look(16'h0000, "R8");
        look(16'hFFF0, "R8");

        // R9: update to the looked-up PC does not alter this cycle's answer
        apply(16'h0ABC, 1'b1, 16'h0ABC, 1'b1, "R9");
        // R6: allocated, seeded weakly taken
        look(16'h0ABC, "R6");
        // R1: same index, different upper bits -> miss
        look(16'h1ABC, "R1");
        look(16'h8ABC, "R1");

        // R4: saturate at top through hits
        for (int k = 0; k < 4; k++) train(16'h0ABC, 1'b1, "R4");
        look(16'h0ABC, "R4");
        train(16'h0ABC, 1'b0, "R4");
        look(16'h0ABC, "R5");       // 11 -> 10 still taken
        train(16'h0ABC, 1'b0, "R4");
        look(16'h0ABC, "R5");       // 01 predicts not-taken
        for (int k = 0; k < 3; k++) train(16'h0ABC, 1'b0, "R4");
        train(16'h0ABC, 1'b1, "R4");
        look(16'h0ABC, "R4");       // floor held, now 01

        // R7: hits above did not touch untagged counter 0x3C
        look(16'h2ABC, "R7");

        // R3: missing update trains the untagged table
        train(16'h0015, 1'b1, "R3");
        look(16'h1015, "R3");
        train(16'h2015, 1'b1, "R3");
        look(16'h3015, "R3");

        // R6: not-taken allocation seeds weakly not-taken, then one taken flips it
        train(16'h0047, 1'b0, "R6");
        look(16'h0047, "R6");
        train(16'h0047, 1'b1, "R6");
        look(16'h0047, "R5");

        // R2/R3/R9: randomized traffic with a small tag space
        for (int k = 0; k < 3000; k++) begin
            logic [PC_W-1:0] a, b;
            a = 16'($urandom) & 16'h0C3F;
            b = ($urandom % 3 == 0) ? a : (16'($urandom) & 16'h0C3F);
            apply(b, 1'($urandom % 4 != 0), a, 1'($urandom % 3 != 0),
                  m_hit(b) ? "R2" : "R3");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule